// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects up to eight level-sensitive interrupt request lines from peripherals and presents a single interrupt line to a processor. Each rising request is held in a request register. A mask register filters the held requests, and a fixed-priority resolver picks the most urgent eligible one. The processor answers the interrupt with two acknowledge strobes. The first strobe moves the winning level from the request register into the in-service register. The second strobe returns an 8-bit vector on the data bus.

A level that is in service holds off its own level and every lower-priority level until it is retired. A more urgent request can still raise the interrupt line again, so service nests. A level is retired in one of two ways: automatically at the second strobe, or later by an end-of-service command written by software. Software reaches the mask, the vector base, the mode bit and both status registers through a small chip-selected register port with one address bit. All strobes are synchronous and last one clock cycle each.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request and in-service registers read 0x00 and the mask register reads 0xFF. The interrupt output is low and the data enable is low.
- R2: A high level on request line k, sampled at a clock edge, sets request bit k. The bit stays set until a first acknowledge grants that level. It can be read at address 0 when the request view is selected, which is the default after reset.
- R3: Setting mask bit k (address 1 write, bit k) stops level k from raising the interrupt output or winning a grant. Masking a level leaves every other level unaffected. If no level is eligible, the interrupt output is low in the following cycle.
- R4: Line 0 has the highest priority and line 7 the lowest. Among simultaneous eligible requests, the lowest-numbered line wins.
- R5: The interrupt output is registered. It goes high one clock after an eligible request bit appears. A first acknowledge strobe clears the winning request bit and sets the matching in-service bit. During that strobe the data enable stays low.
- R6: During a second acknowledge strobe, the data enable is high and the data output carries the programmed base in bits 7:3 and the serviced level number in bits 2:0.
- R7: When the automatic-retire mode bit is set, the second acknowledge clears the serviced in-service bit. When it is clear, the bit stays set.
- R8: Writing 0x01 to address 0 is the end-of-service command. It clears the highest-priority set in-service bit, and the interrupt output is re-evaluated on the next clock.
- R9: While a level is in service, requests at that level and at lower-priority levels do not raise the interrupt output. A higher-priority request does raise it and is granted on top of the current level.
- R10: Address 0 writes decode as follows. If bit 2 is set, the write is a configuration: bits 7:3 give the vector base and bit 0 gives the automatic-retire mode. If bit 2 is clear, bits 1:0 give the command: 01 is end-of-service, 10 selects the request view, 11 selects the in-service view. Reads and writes have no effect while chip select is low.
- R11: An acknowledge sequence that starts with no eligible request sets no in-service bit and returns base with bits 2:0 = 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Level-sensitive request lines, bit 0 highest priority |
| int_out | output | 1 | Interrupt output to the processor |
| ack | input | 1 | Acknowledge strobe, one cycle per pulse |
| cs | input | 1 | Register port chip select |
| rd | input | 1 | Register read strobe |
| wr | input | 1 | Register write strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or vector |
| rdata_oe | output | 1 | Data output enable |

## Verification
Nested service is the hardest state to reach from the ports. It needs one level held in service without automatic retire, a lower-priority request parked behind it, and then a higher-priority request that arrives and is granted on top. The stimulus gets there in steps. It first services a mid-priority level in manual-retire mode, then raises a lower line and checks that the interrupt output stays low, then raises a higher line and acknowledges it. Two end-of-service writes then unwind the stack, and the bench checks the in-service readback and the released low-priority request after each write.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   // command field of an address-0 write when the configuration bit is clear
   typedef enum logic [1:0] {
      CMD_NOP     = 2'b00,
      CMD_EOI     = 2'b01,
      CMD_SEL_REQ = 2'b10,
      CMD_SEL_SRV = 2'b11
   } irq_cmd_e;
   localparam int CFG_BIT  = 2;
   localparam int AUTO_BIT = 0;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic         found,
   output logic [N-1:0] onehot
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;
   for (genvar g = 0; g < N; g++) begin : g_chain
      assign onehot[g]  = req[g] & ~seen[g];
      assign seen[g+1]  = seen[g] | req[g];
   end
   assign found = seen[N];
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
   parameter int N  = 8,
   parameter int LW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ack,
   input  logic          found,
   input  logic [N-1:0]  win_oh,
   output logic          grant,
   output logic          second,
   output logic          phase,
   output logic [LW-1:0] lvl
);
   logic [LW-1:0] win_idx;

   always_comb begin
      win_idx = '0;
      for (int i = 0; i < N; i++)
         if (win_oh[i]) win_idx = win_idx | LW'(i);
   end

   assign grant  = ack & ~phase & found;
   assign second = ack & phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= 1'b0;
         lvl   <= '1;
      end else if (ack) begin
         phase <= ~phase;
         if (!phase) lvl <= found ? win_idx : '1;
      end
   end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import prio_irq_pkg::*;
#(
   parameter int N      = 8,
   parameter int DATA_W = 8,
   parameter int BASE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              rd,
   input  logic              wr,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N-1:0]      irr,
   input  logic [N-1:0]      isr,
   output logic [N-1:0]      imr,
   output logic [BASE_W-1:0] base,
   output logic              auto_eoi,
   output logic              eoi_cmd,
   output logic              rd_en,
   output logic [DATA_W-1:0] rd_val
);
   logic     wr_en, cmd_wr, cfg_wr, sel_srv;
   irq_cmd_e cmd;

   assign wr_en   = cs & wr;
   assign rd_en   = cs & rd;
   assign cmd     = irq_cmd_e'(wdata[1:0]);
   assign cfg_wr  = wr_en & ~addr & wdata[CFG_BIT];
   assign cmd_wr  = wr_en & ~addr & ~wdata[CFG_BIT];
   assign eoi_cmd = cmd_wr & (cmd == CMD_EOI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr      <= '1;
         base     <= '0;
         auto_eoi <= 1'b0;
         sel_srv  <= 1'b0;
      end else begin
         if (wr_en && addr) imr <= wdata[N-1:0];
         if (cfg_wr) begin
            base     <= wdata[DATA_W-1:DATA_W-BASE_W];
            auto_eoi <= wdata[AUTO_BIT];
         end
         if (cmd_wr && cmd == CMD_SEL_REQ) sel_srv <= 1'b0;
         if (cmd_wr && cmd == CMD_SEL_SRV) sel_srv <= 1'b1;
      end
   end

   always_comb begin
      rd_val = '0;
      if (addr)         rd_val[N-1:0] = imr;
      else if (sel_srv) rd_val[N-1:0] = isr;
      else              rd_val[N-1:0] = irr;
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int NUM_LINES = 8,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   output logic              int_out,
   input  logic              ack,
   input  logic              cs,
   input  logic              rd,
   input  logic              wr,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);
   localparam int LVL_W  = $clog2(NUM_LINES);
   localparam int BASE_W = DATA_W - LVL_W;

   if (NUM_LINES != (1 << LVL_W) || NUM_LINES > DATA_W || BASE_W < 1) begin : g_bad_cfg
      $error("prio_irq_ctrl: NUM_LINES must be a power of two no wider than DATA_W");
   end

   logic [NUM_LINES-1:0] irr, isr, imr, allow, elig, win_oh, srv_top, lvl_dec;
   logic [NUM_LINES:0]   blk;
   logic                 win_found, srv_found, grant, second, phase, auto_eoi, eoi_cmd;
   logic                 rd_en, int_q;
   logic [LVL_W-1:0]     lvl;
   logic [BASE_W-1:0]    base;
   logic [DATA_W-1:0]    rd_val;

   // a level is allowed only if no level at or above its priority is in service
   assign blk[0] = 1'b0;
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_block
      assign blk[g+1]  = blk[g] | isr[g];
      assign allow[g]  = ~blk[g+1];
   end

   assign elig = irr & ~imr & allow;

   irq_prio_pick #(.N(NUM_LINES)) u_win (
      .req(elig), .found(win_found), .onehot(win_oh));

   irq_prio_pick #(.N(NUM_LINES)) u_srv (
      .req(isr), .found(srv_found), .onehot(srv_top));

   irq_ack_seq #(.N(NUM_LINES), .LW(LVL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ack(ack), .found(win_found), .win_oh(win_oh),
      .grant(grant), .second(second), .phase(phase), .lvl(lvl));

   irq_reg_port #(.N(NUM_LINES), .DATA_W(DATA_W), .BASE_W(BASE_W)) u_port (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
      .wdata(wdata), .irr(irr), .isr(isr), .imr(imr), .base(base),
      .auto_eoi(auto_eoi), .eoi_cmd(eoi_cmd), .rd_en(rd_en), .rd_val(rd_val));

   assign lvl_dec = {{(NUM_LINES-1){1'b0}}, 1'b1} << lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr   <= '0;
         isr   <= '0;
         int_q <= 1'b0;
      end else begin
         irr <= (irr & ~(grant ? win_oh : '0)) | irq_in;
         isr <= (isr | (grant ? win_oh : '0))
                & ~((second && auto_eoi) ? lvl_dec : '0)
                & ~((eoi_cmd && srv_found) ? srv_top : '0);
         int_q <= |elig;
      end
   end

   assign int_out  = int_q;
   assign rdata    = second ? {base, lvl} : rd_val;
   assign rdata_oe = second | rd_en;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int NUM_LINES = 8,
   parameter int LVL_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ack,
   input logic                 phase,
   input logic                 cs,
   input logic                 rd,
   input logic                 wr,
   input logic                 addr,
   input logic [7:0]           wdata,
   input logic                 rdata_oe,
   input logic                 int_out,
   input logic                 auto_eoi,
   input logic [LVL_W-1:0]     lvl,
   input logic [NUM_LINES-1:0] elig,
   input logic [NUM_LINES-1:0] isr
);
   AST_ACK1_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !phase && !(cs && rd) |-> !rdata_oe); // R5
   AST_GRANT_ADDS_SRV: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !phase && (|elig) && !(cs && wr)
      |=> $countones(isr) == $past($countones(isr)) + 1); // R5
   AST_ACK2_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      ack && phase |-> rdata_oe); // R6
   AST_AUTO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      ack && phase && auto_eoi && isr[lvl] && !(cs && wr)
      |=> $countones(isr) + 1 == $past($countones(isr))); // R7
   AST_EOI_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      cs && wr && !addr && wdata == 8'h01 && (|isr) && !ack
      |=> $countones(isr) + 1 == $past($countones(isr))); // R8
   AST_NO_ELIG_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
      elig == '0 |=> !int_out); // R3
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack), .phase(phase), .cs(cs), .rd(rd),
   .wr(wr), .addr(addr), .wdata(wdata), .rdata_oe(rdata_oe), .int_out(int_out),
   .auto_eoi(auto_eoi), .lvl(lvl), .elig(elig), .isr(isr));

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       ack = 1'b0, cs = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rdata_oe, int_out;

   int n_chk = 0;
   int n_bad = 0;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_out(int_out), .ack(ack),
      .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata),
      .rdata_oe(rdata_oe));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cpu_wr(input logic a, input logic [7:0] d);
      cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
      tick();
      cs = 1'b0; wr = 1'b0; wdata = '0;
   endtask

   task automatic cpu_rd(input logic a, output int v);
      cs = 1'b1; rd = 1'b1; addr = a;
      #1;
      v = rdata_oe ? int'(rdata) : -1;
      tick();
      cs = 1'b0; rd = 1'b0;
   endtask

   task automatic ack1;
      ack = 1'b1;
      #1;
      chk("R5 bus idle on first ack", int'(rdata_oe), 0);
      tick();
      ack = 1'b0;
   endtask

   task automatic ack2(output int v);
      ack = 1'b1;
      #1;
      v = rdata_oe ? int'(rdata) : -1;
      tick();
      ack = 1'b0;
   endtask

   task automatic pulse_irq(input logic [7:0] lines);
      irq_in = lines;
      tick();
      irq_in = '0;
      tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int v;
      int lo, hi, b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 int low", int'(int_out), 0);
      chk("R1 oe low", int'(rdata_oe), 0);
      cpu_rd(1'b1, v); chk("R1 mask all set", v, 8'hFF);
      cpu_rd(1'b0, v); chk("R1 request clear", v, 0);
      cpu_wr(1'b0, 8'h03); cpu_rd(1'b0, v); chk("R1 in-service clear", v, 0);
      cpu_wr(1'b0, 8'h02);

      // R3 masked request raises nothing
      pulse_irq(8'h10); tick();
      chk("R3 masked no int", int'(int_out), 0);
      cpu_rd(1'b0, v); chk("R2 request latched while masked", v, 8'h10);

      // R11 spurious acknowledge, base 0x08
      cpu_wr(1'b0, 8'h0C);
      ack1(); ack2(v);
      chk("R11 spurious vector", v, 8'h0F);
      cpu_wr(1'b0, 8'h03); cpu_rd(1'b0, v); chk("R11 no in-service", v, 0);
      cpu_wr(1'b0, 8'h02);

      // unmask: pending level 4 appears
      cpu_wr(1'b1, 8'h00); tick();
      chk("R5 int after unmask", int'(int_out), 1);
      ack1(); ack2(v); chk("R6 vector level 4", v, 8'h0C);
      cpu_wr(1'b0, 8'h01); tick();

      // R6 R2 R5 R8 single-level sweep over several bases
      for (int bi = 0; bi < 4; bi++) begin
         b = (bi * 8'h48 + 8'h08) & 8'hF8;
         cpu_wr(1'b0, 8'(b | 4));
         for (int l = 0; l < 8; l++) begin
            irq_in = 8'(1 << l);
            tick();
            irq_in = '0;
            chk("R5 int one clock after latch", int'(int_out), 0);
            tick();
            chk("R5 int raised", int'(int_out), 1);
            cpu_rd(1'b0, v); chk("R2 request bit", v, 1 << l);
            ack1();
            cpu_rd(1'b0, v); chk("R5 request cleared by grant", v, 0);
            ack2(v); chk("R6 vector base|level", v, b | l);
            cpu_wr(1'b0, 8'h03); cpu_rd(1'b0, v);
            chk("R7 manual mode keeps in-service", v, 1 << l);
            cpu_wr(1'b0, 8'h01); cpu_rd(1'b0, v);
            chk("R8 eoi clears in-service", v, 0);
            cpu_wr(1'b0, 8'h02);
         end
      end

      // R4 R9 all pairs
      cpu_wr(1'b0, 8'h74);
      for (int i = 0; i < 8; i++) begin
         for (int j = i + 1; j < 8; j++) begin
            lo = i; hi = j;
            pulse_irq(8'((1 << i) | (1 << j)));
            ack1(); ack2(v); chk("R4 lowest line wins", v, 8'h70 | lo);
            chk("R9 lower level held off", int'(int_out), 0);
            cpu_wr(1'b0, 8'h01); tick();
            chk("R8 int after eoi", int'(int_out), 1);
            ack1(); ack2(v); chk("R4 second pending", v, 8'h70 | hi);
            cpu_wr(1'b0, 8'h01); tick();
            chk("R3 idle after both", int'(int_out), 0);
         end
      end

      // R3 masking a higher level leaves a lower one alone
      cpu_wr(1'b1, 8'h01);
      pulse_irq(8'h09);
      chk("R3 lower unmasked raises int", int'(int_out), 1);
      ack1(); ack2(v); chk("R3 masked level skipped", v, 8'h73);
      cpu_wr(1'b0, 8'h01);
      cpu_wr(1'b1, 8'hFF); cpu_rd(1'b1, v); chk("R10 mask readback", v, 8'hFF);
      cpu_wr(1'b0, 8'h03); cpu_rd(1'b0, v); chk("R3 no stray service", v, 0);
      cpu_wr(1'b0, 8'h02); cpu_rd(1'b0, v); chk("R3 level 0 still pending", v, 8'h01);
      cpu_wr(1'b1, 8'h00); tick();
      ack1(); ack2(v); chk("R4 level 0 vector", v, 8'h70);
      cpu_wr(1'b0, 8'h01); tick();

      // R9 nested service
      pulse_irq(8'h20);
      ack1(); ack2(v); chk("R9 outer level 5", v, 8'h75);
      pulse_irq(8'h40); tick();
      chk("R9 lower blocked", int'(int_out), 0);
      pulse_irq(8'h20); tick();
      chk("R9 same level blocked", int'(int_out), 0);
      pulse_irq(8'h04);
      chk("R9 higher raises int", int'(int_out), 1);
      ack1(); ack2(v); chk("R9 nested vector", v, 8'h72);
      cpu_wr(1'b0, 8'h03); cpu_rd(1'b0, v); chk("R9 two in service", v, 8'h24);
      cpu_wr(1'b0, 8'h01); cpu_rd(1'b0, v); chk("R8 eoi clears top", v, 8'h20);
      chk("R9 still blocked", int'(int_out), 0);
      cpu_wr(1'b0, 8'h01); cpu_rd(1'b0, v); chk("R8 eoi clears outer", v, 8'h00);
      chk("R9 released", int'(int_out), 1);
      cpu_wr(1'b0, 8'h02);
      ack1(); ack2(v); chk("R4 level 5 re-served", v, 8'h75);
      cpu_wr(1'b0, 8'h01);
      ack1(); ack2(v); chk("R4 level 6 served", v, 8'h76);
      cpu_wr(1'b0, 8'h01); tick();

      // R7 automatic retire
      cpu_wr(1'b0, 8'h85);
      pulse_irq(8'h08);
      ack1(); ack2(v); chk("R7 vector in auto mode", v, 8'h83);
      cpu_wr(1'b0, 8'h03); cpu_rd(1'b0, v); chk("R7 auto retire", v, 0);
      cpu_wr(1'b0, 8'h02);

      // R10 chip select gating
      cs = 1'b0; wr = 1'b1; addr = 1'b1; wdata = 8'h55; tick(); wr = 1'b0;
      cpu_rd(1'b1, v); chk("R10 write ignored without select", v, 8'h00);
      rd = 1'b1; addr = 1'b1; #1;
      chk("R10 no drive without select", int'(rdata_oe), 0);
      tick(); rd = 1'b0;
      cs = 1'b0; wr = 1'b1; addr = 1'b0; wdata = 8'hF4; tick(); wr = 1'b0;
      pulse_irq(8'h02);
      ack1(); ack2(v); chk("R10 base kept without select", v, 8'h81);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule